// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block is one DMA channel that follows a linked list of descriptors held in memory. It moves data between a word-wide memory port and a device-side data stream. Each descriptor is three 32-bit words at consecutive addresses. The first word is the buffer address, the second is a count-and-flags word, and the third is the address of the next descriptor. The engine fetches a descriptor and transfers the buffer it describes. It then writes the count-and-flags word back with a completion mark. Finally it either fetches the next descriptor or halts.

Software sets a descriptor pointer and a control word through a small register port. The control word picks the direction (memory to device, or device to memory), byte-lane swapping and receive flush. Interrupts are requested per descriptor. A sticky flag collects them and drives `irq`. Reading the control/status view returns that flag and clears it. Data is moved as whole 32-bit words, so a byte count of N moves ceil(N/4) words.

Back-pressure rules:
- A memory request stays valid, with address, direction and data unchanged, until it is accepted by `mem_req_ready`.
- Only one request is ever outstanding. Read data comes back later as a single `mem_rsp_valid` pulse, which the engine always accepts.
- A word on the outbound device stream is held with its data and last flag unchanged until `dout_ready` takes it.
- On the inbound stream the engine raises `din_ready` only while it has room for one word.

Top module: `dma_chain_engine`

## Requirements
- R1: A descriptor at pointer P is fetched as three single-word reads at P, P+4 and P+8, in that order. Each memory request holds valid, address and direction until accepted. A new request is issued only after the previous read's response has arrived.
- R2: The channel starts only when a control write (select 0) has bit 0 (start) and bit 1 (load enable) both set while idle. In the same write, bits 2 (receive direction), 3 (swap) and 4 (flush) are latched. Any other control write leaves the channel idle. Control and pointer writes (select 1) made while active are ignored.
- R3: In transmit mode, word k of a buffer is read from buffer address + 4k and presented on `dout`, for k from 0 to ceil(count/4)-1. The count is bits 13:0 of the info word. `dout_last` is 1 only on the final word, and only when info bit 30 (end of packet) is set. The word is held under back-pressure.
- R4: In receive mode, each accepted `din` word k is written to buffer address + 4k, for up to ceil(count/4) words. `din_ready`, `dout_valid` and `mem_req_valid` are never high together.
- R5: In receive mode with flush enabled, a `din` word with `din_last` set is written and ends the buffer early. With flush disabled, `din_last` has no effect.
- R6: When swap is enabled, every data word reverses its four byte lanes between memory and the device stream, in both directions.
- R7: After each buffer, the info word is written back to P+4. In transmit mode it is written with bit 15 set. In receive mode it is written with bit 14 cleared.
- R8: If info bit 31 is clear, the engine fetches the descriptor at the third word's address. If it is set, the engine stops after the write-back and active status falls to 0.
- R9: A descriptor whose byte count is 0 moves no data and goes straight to its write-back.
- R10: The write-back of a descriptor with info bit 29 set raises the interrupt flag (`irq` and status bit 0). A status read (select 0) returns the flag and clears it, unless a new set happens in the same cycle.
- R11: The status view is read at select 0. Bit 1 is active. Bit 2 is 1 while active and the loaded descriptor has bit 31 set, meaning a newly appended descriptor would no longer be followed. Bits 5:3 echo receive, swap and flush. Select 1 reads the descriptor pointer.
- R12: After reset the channel is idle with `irq`, all valid/ready outputs and the status word at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt on select 0) |
| reg_sel | input | 1 | 0 = control/status, 1 = descriptor pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Word address in bytes |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| dout_valid | output | 1 | Outbound device word valid |
| dout_ready | input | 1 | Device accepts outbound word |
| dout_data | output | 32 | Outbound device word |
| dout_last | output | 1 | Outbound word ends a packet |
| din_valid | input | 1 | Inbound device word valid |
| din_ready | output | 1 | Engine accepts inbound word |
| din_data | input | 32 | Inbound device word |
| din_last | input | 1 | Inbound word ends a packet |

## Verification
The assertions assume the memory returns exactly one response per accepted read, never unsolicited, and only while the engine waits for it. They also assume software writes the pointer and control only while idle. The stimulus respects these assumptions with a bench memory model that answers each read one cycle after acceptance. The bench gives register access only between chains, or as status reads while a chain runs. Ready signals on the memory and outbound stream follow fixed stall patterns, and the inbound source holds each word until taken, so the hold-under-stall properties are exercised without breaking the handshake rules.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int CNT_W     = 14;
  localparam int WORDS_W   = CNT_W - 1;
  localparam int INFO_EOX  = 31;
  localparam int INFO_EOP  = 30;
  localparam int INFO_XIE  = 29;
  localparam int INFO_SENT = 15;
  localparam int INFO_OWN  = 14;

  localparam int CW_ACT   = 0;
  localparam int CW_LD    = 1;
  localparam int CW_RX    = 2;
  localparam int CW_SWAP  = 3;
  localparam int CW_FLUSH = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_TREQ, S_TWAIT, S_TOUT, S_RIN, S_RWR, S_WB
  } dma_state_e;

  typedef struct packed {
    logic               eox;
    logic               eop;
    logic               xie;
    logic [WORDS_W-1:0] words;
  } desc_info_t;
endpackage

// File: rtl/dma_lane_swap.sv
module dma_lane_swap #(
  parameter int LANES = 4
) (
  input  logic               en,
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);
  logic [8*LANES-1:0] rev;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rev[8*i +: 8] = din[8*(LANES-1-i) +: 8];
  end
  assign dout = en ? rev : din;
endmodule

// File: rtl/dma_desc_decode.sv
module dma_desc_decode
  import dma_chain_pkg::*;
(
  input  logic [31:0] info_word,
  input  logic        rx_mode,
  output desc_info_t  fields,
  output logic [31:0] wb_word
);
  logic [CNT_W:0] rounded;

  always_comb begin
    rounded       = {1'b0, info_word[CNT_W-1:0]} + (CNT_W+1)'(3);
    fields.eox    = info_word[INFO_EOX];
    fields.eop    = info_word[INFO_EOP];
    fields.xie    = info_word[INFO_XIE];
    fields.words  = rounded[CNT_W:2];
    wb_word       = info_word;
    if (rx_mode) wb_word[INFO_OWN]  = 1'b0;
    else         wb_word[INFO_SENT] = 1'b1;
  end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          dout_valid,
  input  logic          dout_ready,
  output logic [31:0]   dout_data,
  output logic          dout_last,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [31:0]   din_data,
  input  logic          din_last
);
  localparam int LANES = 4;

  dma_state_e         state;
  logic [AW-1:0]      ptr, nxt, buf_a;
  logic [31:0]        info, word_q, word_sw, wb_word;
  logic [1:0]         idx;
  logic [WORDS_W-1:0] wcnt, wnext;
  logic               irq_q, info_ok, early;
  logic               cfg_rx, cfg_swap, cfg_flush;
  logic               active, final_word, ctrl_wr, irq_set;
  desc_info_t         dsc;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata[31:5];

  dma_desc_decode u_dec (
    .info_word(info), .rx_mode(cfg_rx), .fields(dsc), .wb_word(wb_word)
  );

  dma_lane_swap #(.LANES(LANES)) u_swap (
    .en(cfg_swap), .din(word_q), .dout(word_sw)
  );

  assign active     = (state != S_IDLE);
  assign wnext      = wcnt + 1'b1;
  assign final_word = (wnext == dsc.words);
  assign ctrl_wr    = reg_wr && !reg_sel && !active;
  assign irq_set    = (state == S_WB) && mem_req_ready && dsc.xie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; ptr <= '0; nxt <= '0; buf_a <= '0; info <= '0;
      word_q <= '0; idx <= '0; wcnt <= '0; irq_q <= 1'b0; info_ok <= 1'b0;
      early <= 1'b0; cfg_rx <= 1'b0; cfg_swap <= 1'b0; cfg_flush <= 1'b0;
    end else begin
      irq_q <= irq_set || (irq_q && !(reg_rd && !reg_sel));
      case (state)
        S_IDLE: begin
          if (reg_wr && reg_sel) ptr <= reg_wdata[AW-1:0];
          if (ctrl_wr) begin
            cfg_rx    <= reg_wdata[CW_RX];
            cfg_swap  <= reg_wdata[CW_SWAP];
            cfg_flush <= reg_wdata[CW_FLUSH];
            if (reg_wdata[CW_ACT] && reg_wdata[CW_LD]) begin
              state <= S_FREQ; idx <= '0; info_ok <= 1'b0;
            end
          end
        end
        S_FREQ: if (mem_req_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_rsp_valid) begin
          case (idx)
            2'd0:    buf_a <= mem_rsp_data[AW-1:0];
            2'd1:    begin info <= mem_rsp_data; info_ok <= 1'b1; end
            default: nxt <= mem_rsp_data[AW-1:0];
          endcase
          if (idx == 2'd2) begin
            wcnt  <= '0;
            early <= 1'b0;
            if (dsc.words == '0) state <= S_WB;
            else state <= cfg_rx ? S_RIN : S_TREQ;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_FREQ;
          end
        end
        S_TREQ: if (mem_req_ready) state <= S_TWAIT;
        S_TWAIT: if (mem_rsp_valid) begin
          word_q <= mem_rsp_data;
          state  <= S_TOUT;
        end
        S_TOUT: if (dout_ready) begin
          wcnt  <= wnext;
          state <= final_word ? S_WB : S_TREQ;
        end
        S_RIN: if (din_valid) begin
          word_q <= din_data;
          early  <= cfg_flush && din_last;
          state  <= S_RWR;
        end
        S_RWR: if (mem_req_ready) begin
          wcnt  <= wnext;
          state <= (final_word || early) ? S_WB : S_RIN;
        end
        S_WB: if (mem_req_ready) begin
          if (dsc.eox) state <= S_IDLE;
          else begin
            ptr <= nxt; idx <= '0; info_ok <= 1'b0; state <= S_FREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (state == S_FREQ) || (state == S_TREQ) ||
                    (state == S_RWR)  || (state == S_WB);
    mem_req_we    = (state == S_RWR) || (state == S_WB);
    mem_req_wdata = (state == S_WB) ? wb_word : word_sw;
    case (state)
      S_FREQ:        mem_req_addr = ptr + AW'({idx, 2'b00});
      S_TREQ, S_RWR: mem_req_addr = buf_a + AW'({wcnt, 2'b00});
      default:       mem_req_addr = ptr + AW'(4);
    endcase
    dout_valid = (state == S_TOUT);
    dout_data  = word_sw;
    dout_last  = dsc.eop && final_word;
    din_ready  = (state == S_RIN);
    irq        = irq_q;
    if (reg_sel) reg_rdata = 32'(ptr);
    else reg_rdata = {26'b0, cfg_flush, cfg_swap, cfg_rx,
                      active && info_ok && dsc.eox, active, irq_q};
  end

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  assert_start_ld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(reg_wr && !reg_sel && reg_wdata[CW_ACT] && reg_wdata[CW_LD]));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_data) && $stable(dout_last));

  assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, dout_valid, din_ready}));

  assert_stop_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(info[INFO_EOX]));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(info[INFO_XIE]));
endmodule

// File: tb/dma_chain_engine_bench.sv
module dma_chain_engine_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {logic we; logic [31:0] addr; logic [31:0] data; string tag;} mtx_t;
  typedef struct {logic [31:0] data; logic last;} wd_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  logic mem_req_valid, mem_req_ready = 0, mem_req_we, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data = '0;
  logic dout_valid, dout_ready = 0, dout_last, din_valid = 0, din_ready, din_last = 0;
  logic [31:0] dout_data, din_data = '0;

  int vectors = 0, miscompares = 0;
  logic [31:0] mem [logic [31:0]];
  mtx_t exp_m[$];
  wd_t  exp_o[$];
  wd_t  rx_src[$];
  int stall_at = -1, sunk = 0, cyc = 0, mem_seen = 0;
  bit rsp_pend = 0;
  logic [31:0] rsp_word = '0;
  string dtag_o = "R3";

  dma_chain_engine u_dma_chain_engine (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata, .reg_rdata, .irq,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data, .dout_valid, .dout_ready, .dout_data, .dout_last,
    .din_valid, .din_ready, .din_data, .din_last
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sw(logic [31:0] w, bit en);
    return en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_m(logic we, logic [31:0] a, logic [31:0] d, string tag);
    mtx_t t;
    t.we = we; t.addr = a; t.data = d; t.tag = tag;
    exp_m.push_back(t);
  endtask

  // Behavioural reference: walk the chain in bench memory and queue expectations
  task automatic model(logic [31:0] p0, bit rx, bit swp, bit fl, string dtag);
    logic [31:0] p, b, inf, nx;
    int n, ri;
    wd_t w, o;
    p = p0; ri = 0;
    for (int d = 0; d < 8; d++) begin
      b = mem[p]; inf = mem[p+4]; nx = mem[p+8];
      for (int k = 0; k < 3; k++) push_m(1'b0, p + 4*k, '0, "R1");
      n = ((inf & 32'h3fff) + 3) / 4;
      for (int k = 0; k < n; k++) begin
        if (!rx) begin
          push_m(1'b0, b + 4*k, '0, dtag);
          o.data = sw(mem[b + 4*k], swp); o.last = inf[30] && (k == n-1);
          exp_o.push_back(o);
        end else begin
          w = rx_src[ri]; ri++;
          push_m(1'b1, b + 4*k, sw(w.data, swp), dtag);
          if (fl && w.last) break;
        end
      end
      push_m(1'b1, p + 4, rx ? (inf & ~32'h4000) : (inf | 32'h8000), (n == 0) ? "R9" : "R7");
      if (inf[31]) break;
      p = nx;
    end
  endtask

  // Memory, device sink and device source models; watchdog
  initial begin
    mtx_t e;
    wd_t o;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        miscompares++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin mem_rsp_valid = 1'b1; mem_rsp_data = rsp_word; rsp_pend = 0; end
      mem_req_ready = (cyc % 3) != 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        mem_seen++;
        if (exp_m.size() == 0) check(1'b0, "R1", "unexpected request", mem_req_addr, '0);
        else begin
          e = exp_m.pop_front();
          check(mem_req_addr == e.addr, e.tag, "request address", mem_req_addr, e.addr);
          check(mem_req_we == e.we, e.tag, "request direction", 32'(mem_req_we), 32'(e.we));
          if (e.we) check(mem_req_wdata == e.data, e.tag, "write data", mem_req_wdata, e.data);
        end
        if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
        else begin
          rsp_pend = 1;
          rsp_word = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
        end
      end
      dout_ready = (sunk != stall_at) && ((cyc % 4) != 2);
      if (rst_n && dout_valid && dout_ready) begin
        if (exp_o.size() == 0) check(1'b0, "R3", "unexpected dout", dout_data, '0);
        else begin
          o = exp_o.pop_front();
          check(dout_data == o.data, dtag_o, "dout data", dout_data, o.data);
          check(dout_last == o.last, "R3", "dout last", 32'(dout_last), 32'(o.last));
        end
        sunk++;
      end
      din_valid = rx_src.size() > 0;
      if (din_valid) begin din_data = rx_src[0].data; din_last = rx_src[0].last; end
      if (din_valid && din_ready) void'(rx_src.pop_front());
    end
  end

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && (exp_m.size() != 0 || exp_o.size() != 0); i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(exp_m.size() == 0, "R8", "memory transactions left", exp_m.size(), 0);
    check(exp_o.size() == 0, "R3", "dout words left", exp_o.size(), 0);
  endtask

  task automatic put_desc(logic [31:0] p, logic [31:0] b, logic [31:0] inf, logic [31:0] nx);
    mem[p] = b; mem[p+4] = inf; mem[p+8] = nx;
  endtask

  task automatic put_rx(logic [31:0] d, logic l);
    wd_t w;
    w.data = d; w.last = l;
    rx_src.push_back(w);
  endtask

  initial begin
    logic [31:0] r;
    int seen0;
    // R12 reset state
    repeat (4) @(negedge clk);
    check(irq == 0 && mem_req_valid == 0 && dout_valid == 0 && din_ready == 0,
          "R12", "outputs in reset", {irq, mem_req_valid, dout_valid, din_ready}, 0);
    rst_n = 1'b1;
    rd(1'b0, r);
    check(r == 0, "R12", "status after reset", r, 0);

    // R2 start needs load enable
    seen0 = mem_seen;
    wr(1'b1, 32'h100);
    wr(1'b0, 32'h1);
    wr(1'b0, 32'h2);
    repeat (10) @(negedge clk);
    rd(1'b0, r);
    check(r[1] == 0, "R2", "active without load enable", r, 0);
    check(mem_seen == seen0, "R2", "requests without start", mem_seen, seen0);

    // Transmit chain: 8 bytes, zero-count with interrupt, 5 bytes end of packet and chain
    put_desc(32'h100, 32'h1000, 32'h0000_0008, 32'h200);
    put_desc(32'h200, 32'h1100, 32'h2000_0000, 32'h300);
    put_desc(32'h300, 32'h1200, 32'hC000_0005, 32'hDEAD_0000);
    for (int k = 0; k < 2; k++) mem[32'h1000 + 4*k] = 32'hA0A1_A2A3 + k;
    for (int k = 0; k < 2; k++) mem[32'h1200 + 4*k] = 32'hB0B1_B2B3 + k;
    dtag_o = "R3";
    model(32'h100, 1'b0, 1'b0, 1'b0, "R3");
    stall_at = 0;
    wr(1'b1, 32'h100);
    wr(1'b0, 32'h3);
    repeat (30) @(negedge clk);
    rd(1'b0, r);
    check(r == 32'h2, "R11", "status during first descriptor", r, 32'h2);
    wr(1'b1, 32'h900);
    rd(1'b1, r);
    check(r == 32'h100, "R2", "pointer write ignored while active", r, 32'h100);
    stall_at = 2;
    repeat (120) @(negedge clk);
    check(irq == 1, "R10", "irq after zero-count descriptor", 32'(irq), 1);
    rd(1'b0, r);
    check(r == 32'h7, "R11", "status on last descriptor", r, 32'h7);
    check(irq == 0, "R10", "irq cleared by status read", 32'(irq), 0);
    stall_at = -1;
    wait_done();
    rd(1'b0, r);
    check(r == 32'h0, "R8", "status after chain end", r, 32'h0);
    check(mem[32'h104] == 32'h0000_8008, "R7", "tx write-back", mem[32'h104], 32'h0000_8008);
    check(mem[32'h304] == 32'hC000_8005, "R7", "tx last write-back", mem[32'h304], 32'hC000_8005);

    // Receive with swap and flush: packet end truncates the first buffer
    put_desc(32'h400, 32'h2000, 32'h2000_400C, 32'h500);
    put_desc(32'h500, 32'h2100, 32'h8000_4008, 32'h0);
    for (int k = 0; k < 3; k++) begin mem[32'h2000 + 4*k] = 0; mem[32'h2100 + 4*k] = 0; end
    put_rx(32'h1122_3344, 1'b0);
    put_rx(32'h5566_7788, 1'b1);
    put_rx(32'h99AA_BBCC, 1'b0);
    put_rx(32'hDDEE_FF00, 1'b1);
    model(32'h400, 1'b1, 1'b1, 1'b1, "R6");
    wr(1'b1, 32'h400);
    wr(1'b0, 32'h1F);
    wait_done();
    rd(1'b0, r);
    check(r == 32'h39, "R10", "status after rx chain", r, 32'h39);
    check(mem[32'h2008] == 0, "R5", "flush left word unwritten", mem[32'h2008], 0);
    check(mem[32'h2004] == 32'h8877_6655, "R6", "rx swapped word", mem[32'h2004], 32'h8877_6655);
    check(mem[32'h404] == 32'h2000_000C, "R7", "rx ownership cleared", mem[32'h404], 32'h2000_000C);

    // Receive without flush: end of packet ignored
    put_desc(32'h600, 32'h3000, 32'h8000_4006, 32'h0);
    put_rx(32'hCAFE_0001, 1'b1);
    put_rx(32'hCAFE_0002, 1'b0);
    model(32'h600, 1'b1, 1'b0, 1'b0, "R5");
    wr(1'b1, 32'h600);
    wr(1'b0, 32'h07);
    wait_done();
    check(mem[32'h3004] == 32'hCAFE_0002, "R5", "second word after ignored last", mem[32'h3004], 32'hCAFE_0002);
    check(rx_src.size() == 0, "R4", "rx words consumed", rx_src.size(), 0);
    rd(1'b0, r);
    check(r == 32'h08, "R8", "status after rx without flush", r, 32'h08);

    // Transmit with swap, 3 bytes = one word
    put_desc(32'h700, 32'h4000, 32'hC000_0003, 32'h0);
    mem[32'h4000] = 32'h0102_0304;
    dtag_o = "R6";
    model(32'h700, 1'b0, 1'b1, 1'b0, "R6");
    wr(1'b1, 32'h700);
    wr(1'b0, 32'h0B);
    wait_done();
    rd(1'b0, r);
    check(r == 32'h10, "R6", "status after swapped tx", r, 32'h10);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule